// File: doc/BRIEF.md
# PHY Bring-Up Sequencer

This block brings a serial link PHY out of reset without software stepping through each access. On a start request it sends commands to a separate register-port handshake master: it selects the PHY clock/reset register, writes the reset value, and then polls a lane status register until the receive PLL reports lock. Between polls it waits a fixed number of cycles. It stops in one of two ends: ready, or failed with a status code that gives the cause.

The handshake master takes one command at a time. The command has an operation, address select, data write or read, and a 16-bit data word. For select and read commands the sequencer holds the request until the master answers with a done pulse, which may carry an error flag. The reset write is only issued. The sequencer never waits for a done on it, because a PHY in reset cannot answer. A separate low-power request takes the link down for good: the power-down output latches on, and only a block reset clears it.

Top module: `phy_bringup_seq`

## Requirements
- R1: After reset, ready, failed, pddq and cmdValid are 0 and status is 0 (none).
- R2: A start request accepted in the idle, ready or failed state first issues a select command (cmdOp 0) with cmdData 0x7F3F and holds it until cmdDone. It then issues exactly one write command (cmdOp 1) with cmdData 0x0001 (bit 0 is the reset bit). The write lasts one cycle and the sequencer does not wait for cmdDone on it.
- R3: Before each status poll the sequencer waits DELAY_CYCLES cycles. The first poll's select command asserts cmdValid exactly DELAY_CYCLES+1 cycles after the cycle of the reset write.
- R4: Each poll issues a select command with cmdData 0x2003, then a read command (cmdOp 2). Each is held until cmdDone. If bit 1 of rdData is set when the read completes, the sequencer ends with ready=1. Other rdData bits have no effect.
- R5: If MAX_POLLS reads complete without lock, the sequencer ends with failed=1 and status 1 (timeout), after exactly MAX_POLLS reads.
- R6: A cmdDone with cmdErr=1 on any select or read command aborts the sequence. The sequencer then has failed=1 and status 2 (command error) and issues no further commands.
- R7: A start request while a sequence is in progress is ignored. The running sequence continues and issues no second reset write.
- R8: pddqReq sets pddq, which stays 1 until reset. It forces failed=1 with status 3 (link disabled) on the next cycle. While pddq is 1, start requests are ignored and no commands are issued.
- R9: ready and failed are never both 1, and cmdValid is 0 while ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | Begin a bring-up sequence |
| pddqReq | input | 1 | Request permanent link power-down |
| cmdValid | output | 1 | Command request to the handshake master |
| cmdOp | output | 2 | 0 select address, 1 write, 2 read |
| cmdData | output | 16 | Register address or write value |
| cmdDone | input | 1 | Master finished the held command |
| cmdErr | input | 1 | Master reports failure with cmdDone |
| rdData | input | 16 | Read result, valid with cmdDone on a read |
| ready | output | 1 | PLL locked, sequence complete |
| failed | output | 1 | Sequence ended without lock |
| status | output | 2 | 0 none, 1 timeout, 2 command error, 3 link disabled |
| pddq | output | 1 | Sticky low-power request to the PHY |

## Verification
The sweep moves the lock point across the whole retry window, including lock on the first and the last allowed poll and one read past it. A retry count off by one would time out on a link that did lock, or give one extra poll. Status words with every bit set except bit 1 would expose a lock test on the wrong bit. The reset write is checked for one-shot issue and for the exact wait before the first poll, so a design that waited for an acknowledge there, or miscounted the delay, would hang or shift the poll. Errors are injected at every command position. Power-down is raised mid-run and followed by a restart attempt, which would catch a design that kept polling or let pddq clear.

// File: rtl/phy_bringup_pkg.sv
package phy_bringup_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR_RST,
    ST_WRITE_RST,
    ST_DELAY,
    ST_ADDR_STAT,
    ST_READ_STAT,
    ST_CHECK,
    ST_READY,
    ST_ERROR
  } seqState_e;

  typedef enum logic [1:0] {
    OP_ADDR  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2
  } cmdOp_e;

  typedef enum logic [1:0] {
    STS_NONE     = 2'd0,
    STS_TIMEOUT  = 2'd1,
    STS_CMD_FAIL = 2'd2,
    STS_LINK_OFF = 2'd3
  } seqStatus_e;

  // control -> datapath strobes
  typedef struct packed {
    logic clrRun;     // new sequence: clear poll count
    logic delayTick;  // in the inter-poll wait
    logic incPoll;    // a poll ended without lock
    logic captureRd;  // latch the lock bit of the read word
    logic setPddq;    // latch low-power request
    logic selStat;    // address the status register
    logic selWrite;   // drive the reset value
  } dpStrobe_t;

endpackage

// File: rtl/phy_bringup_dp.sv
module phy_bringup_dp
  import phy_bringup_pkg::*;
#(
  parameter int          DATA_W       = 16,
  parameter int          DELAY_CYCLES = 128,
  parameter int          MAX_POLLS    = 100,
  parameter logic [15:0] RST_REG      = 16'h7F3F,
  parameter logic [15:0] RST_VAL      = 16'h0001,
  parameter logic [15:0] STAT_REG     = 16'h2003,
  parameter int          LOCK_BIT     = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] cmdData,
  output logic              delayDone,
  output logic              pollLast,
  output logic              lockSeen,
  output logic              pddq
);

  localparam int DLY_W  = $clog2(DELAY_CYCLES + 1);
  localparam int POLL_W = $clog2(MAX_POLLS + 1);
  localparam logic [DATA_W-1:0] LOCK_MASK = DATA_W'(1) << LOCK_BIT;

  logic [DLY_W-1:0]  delayCnt;
  logic [POLL_W-1:0] pollCnt;
  logic              lockReg;
  logic              pddqReg;

  assign delayDone = (delayCnt == DLY_W'(DELAY_CYCLES - 1));
  assign pollLast  = (pollCnt == POLL_W'(MAX_POLLS - 1));
  assign lockSeen  = lockReg;
  assign pddq      = pddqReg;

  always_comb begin
    if (stb.selStat)       cmdData = DATA_W'(STAT_REG);
    else if (stb.selWrite) cmdData = DATA_W'(RST_VAL);
    else                   cmdData = DATA_W'(RST_REG);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      delayCnt <= '0;
      pollCnt  <= '0;
      lockReg  <= 1'b0;
      pddqReg  <= 1'b0;
    end else begin
      if (stb.delayTick && !delayDone) delayCnt <= delayCnt + 1'b1;
      else                             delayCnt <= '0;

      if (stb.clrRun)       pollCnt <= '0;
      else if (stb.incPoll) pollCnt <= pollCnt + 1'b1;

      if (stb.clrRun)         lockReg <= 1'b0;
      else if (stb.captureRd) lockReg <= |(rdData & LOCK_MASK);

      if (stb.setPddq) pddqReg <= 1'b1;
    end
  end

endmodule

// File: rtl/phy_bringup_ctrl.sv
module phy_bringup_ctrl
  import phy_bringup_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       pddqReq,
  input  logic       cmdDone,
  input  logic       cmdErr,
  input  logic       delayDone,
  input  logic       pollLast,
  input  logic       lockSeen,
  input  logic       pddq,
  output dpStrobe_t  stb,
  output logic       cmdValid,
  output logic [1:0] cmdOp,
  output logic       ready,
  output logic       failed,
  output logic [1:0] status
);

  seqState_e  state, stateNxt;
  seqStatus_e stsReg, stsNxt;
  logic       startOk;

  assign ready  = (state == ST_READY);
  assign failed = (state == ST_ERROR);
  assign status = stsReg;

  assign startOk = startReq && !pddq &&
                   (state == ST_IDLE || state == ST_READY || state == ST_ERROR);

  always_comb begin
    stateNxt = state;
    stsNxt   = stsReg;
    stb      = '0;
    cmdValid = 1'b0;
    cmdOp    = OP_ADDR;
    case (state)
      ST_IDLE, ST_READY, ST_ERROR: begin
        if (startOk) begin
          stateNxt   = ST_ADDR_RST;
          stsNxt     = STS_NONE;
          stb.clrRun = 1'b1;
        end
      end
      ST_ADDR_RST: begin
        cmdValid = 1'b1;
        if (cmdDone) begin
          if (cmdErr) begin
            stateNxt = ST_ERROR;
            stsNxt   = STS_CMD_FAIL;
          end else begin
            stateNxt = ST_WRITE_RST;
          end
        end
      end
      ST_WRITE_RST: begin
        // PHY in reset cannot acknowledge: issue and move on
        cmdValid     = 1'b1;
        cmdOp        = OP_WRITE;
        stb.selWrite = 1'b1;
        stateNxt     = ST_DELAY;
      end
      ST_DELAY: begin
        stb.delayTick = 1'b1;
        if (delayDone) stateNxt = ST_ADDR_STAT;
      end
      ST_ADDR_STAT: begin
        cmdValid    = 1'b1;
        stb.selStat = 1'b1;
        if (cmdDone) begin
          if (cmdErr) begin
            stateNxt = ST_ERROR;
            stsNxt   = STS_CMD_FAIL;
          end else begin
            stateNxt = ST_READ_STAT;
          end
        end
      end
      ST_READ_STAT: begin
        cmdValid    = 1'b1;
        cmdOp       = OP_READ;
        stb.selStat = 1'b1;
        if (cmdDone) begin
          if (cmdErr) begin
            stateNxt = ST_ERROR;
            stsNxt   = STS_CMD_FAIL;
          end else begin
            stb.captureRd = 1'b1;
            stateNxt      = ST_CHECK;
          end
        end
      end
      ST_CHECK: begin
        if (lockSeen) begin
          stateNxt = ST_READY;
        end else begin
          stb.incPoll = 1'b1;
          if (pollLast) begin
            stateNxt = ST_ERROR;
            stsNxt   = STS_TIMEOUT;
          end else begin
            stateNxt = ST_DELAY;
          end
        end
      end
      default: stateNxt = ST_IDLE;
    endcase

    // power-down overrides everything
    if (pddqReq) begin
      stb         = '0;
      stb.setPddq = 1'b1;
      stateNxt    = ST_ERROR;
      stsNxt      = STS_LINK_OFF;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      stsReg <= STS_NONE;
    end else begin
      state  <= stateNxt;
      stsReg <= stsNxt;
    end
  end

endmodule

// File: rtl/phy_bringup_seq.sv
module phy_bringup_seq
  import phy_bringup_pkg::*;
#(
  parameter int          DATA_W       = 16,
  parameter int          DELAY_CYCLES = 128,
  parameter int          MAX_POLLS    = 100,
  parameter logic [15:0] RST_REG      = 16'h7F3F,
  parameter logic [15:0] RST_VAL      = 16'h0001,
  parameter logic [15:0] STAT_REG     = 16'h2003,
  parameter int          LOCK_BIT     = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              pddqReq,
  output logic              cmdValid,
  output logic [1:0]        cmdOp,
  output logic [DATA_W-1:0] cmdData,
  input  logic              cmdDone,
  input  logic              cmdErr,
  input  logic [DATA_W-1:0] rdData,
  output logic              ready,
  output logic              failed,
  output logic [1:0]        status,
  output logic              pddq
);

  dpStrobe_t stb;
  logic      delayDone;
  logic      pollLast;
  logic      lockSeen;

  phy_bringup_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startReq  (startReq),
    .pddqReq   (pddqReq),
    .cmdDone   (cmdDone),
    .cmdErr    (cmdErr),
    .delayDone (delayDone),
    .pollLast  (pollLast),
    .lockSeen  (lockSeen),
    .pddq      (pddq),
    .stb       (stb),
    .cmdValid  (cmdValid),
    .cmdOp     (cmdOp),
    .ready     (ready),
    .failed    (failed),
    .status    (status)
  );

  phy_bringup_dp #(
    .DATA_W       (DATA_W),
    .DELAY_CYCLES (DELAY_CYCLES),
    .MAX_POLLS    (MAX_POLLS),
    .RST_REG      (RST_REG),
    .RST_VAL      (RST_VAL),
    .STAT_REG     (STAT_REG),
    .LOCK_BIT     (LOCK_BIT)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .rdData    (rdData),
    .cmdData   (cmdData),
    .delayDone (delayDone),
    .pollLast  (pollLast),
    .lockSeen  (lockSeen),
    .pddq      (pddq)
  );

endmodule

// File: rtl/phy_bringup_chk.sv
module phy_bringup_chk #(
  parameter int          DATA_W  = 16,
  parameter logic [15:0] RST_VAL = 16'h0001
) (
  input logic              clk,
  input logic              rstN,
  input logic              pddqReq,
  input logic              cmdValid,
  input logic [1:0]        cmdOp,
  input logic [DATA_W-1:0] cmdData,
  input logic              cmdDone,
  input logic              cmdErr,
  input logic              ready,
  input logic              failed,
  input logic [1:0]        status,
  input logic              pddq
);

  // R2: reset write is a single-cycle, fixed-value command
  assert_write_value_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 2'd1) |-> (cmdData == DATA_W'(RST_VAL)));

  assert_write_one_shot_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 2'd1) |=> !(cmdValid && cmdOp == 2'd1));

  // R6: an errored answer aborts with command-error status
  assert_cmd_abort_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp != 2'd1 && cmdDone && cmdErr && !pddqReq)
      |=> (failed && status == 2'd2 && !cmdValid));

  // R8: power-down request latches and forces link-off
  assert_pddq_force_R8: assert property (@(posedge clk) disable iff (!rstN)
    pddqReq |=> (pddq && failed && status == 2'd3));

  assert_pddq_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    pddq |=> pddq);

  assert_pddq_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    $past(pddq) |-> !cmdValid);

  // R9: exclusive end states, no command while ready
  assert_end_exclusive_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(ready && failed));

  assert_ready_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> !cmdValid);

endmodule

bind phy_bringup_seq phy_bringup_chk #(
  .DATA_W  (DATA_W),
  .RST_VAL (RST_VAL)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .pddqReq  (pddqReq),
  .cmdValid (cmdValid),
  .cmdOp    (cmdOp),
  .cmdData  (cmdData),
  .cmdDone  (cmdDone),
  .cmdErr   (cmdErr),
  .ready    (ready),
  .failed   (failed),
  .status   (status),
  .pddq     (pddq)
);

// File: tb/tb_phy_bringup_seq.sv
`timescale 1ns/1ps
module tb_phy_bringup_seq;

  localparam int DLY   = 4;
  localparam int POLLS = 5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic        pddqReq = 1'b0;
  logic        cmdValid;
  logic [1:0]  cmdOp;
  logic [15:0] cmdData;
  logic        cmdDone = 1'b0;
  logic        cmdErr = 1'b0;
  logic [15:0] rdData = 16'h0000;
  logic        ready, failed, pddq;
  logic [1:0]  status;

  always #10 clk = ~clk;

  phy_bringup_seq #(.DELAY_CYCLES(DLY), .MAX_POLLS(POLLS)) dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .pddqReq(pddqReq),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdData(cmdData),
    .cmdDone(cmdDone), .cmdErr(cmdErr), .rdData(rdData),
    .ready(ready), .failed(failed), .status(status), .pddq(pddq)
  );

  int vecs = 0;
  int fails = 0;
  int cyc = 0;

  // master model configuration and logs
  int lat = 0, lockAfter = 0, errAt = -1;
  int rspCnt = 0, ackIdx = 0, readIdx = 0;
  int wrCnt = 0, writeCyc = -1, firstStatCyc = -1, validCnt = 0;
  logic [15:0] wrData = 16'h0, firstAddr = 16'h0;
  bit addrSeen = 0;

  always @(negedge clk) begin
    cyc++;
    if (cmdValid) validCnt++;
    if (cmdValid && cmdOp == 2'd1) begin
      wrCnt++; wrData = cmdData; writeCyc = cyc;
    end
    if (cmdValid && cmdOp == 2'd0 && !addrSeen) begin
      addrSeen = 1; firstAddr = cmdData;
    end
    if (cmdValid && cmdOp == 2'd0 && cmdData == 16'h2003 && firstStatCyc < 0)
      firstStatCyc = cyc;
    if (cmdDone) begin
      cmdDone = 0; cmdErr = 0; rspCnt = 0;
    end else if (cmdValid && cmdOp != 2'd1) begin
      if (rspCnt == lat) begin
        cmdDone = 1;
        if (ackIdx == errAt) cmdErr = 1;
        ackIdx++;
        if (cmdOp == 2'd2) begin
          rdData = (readIdx >= lockAfter) ? 16'h0002 : 16'hFFFD;
          readIdx++;
        end
      end else rspCnt++;
    end else rspCnt = 0;
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual run still active, expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic check(bit ok, string req, int act, int exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d (0x%0h), expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic clearLogs();
    ackIdx = 0; readIdx = 0; wrCnt = 0; writeCyc = -1;
    firstStatCyc = -1; addrSeen = 0; firstAddr = 16'h0;
  endtask

  task automatic doReset();
    rstN = 0; startReq = 0; pddqReq = 0;
    repeat (3) tick();
    rstN = 1;
    tick();
  endtask

  task automatic pulseStart();
    startReq = 1; tick(); startReq = 0;
  endtask

  task automatic waitEnd();
    for (int i = 0; i < 3000 && !(ready || failed); i++) tick();
  endtask

  task automatic checkQuiet(string req);
    validCnt = 0;
    repeat (10) tick();
    check(validCnt == 0, req, validCnt, 0);
  endtask

  // R1: reset state
  task automatic checkResetState();
    check(!ready && !failed, "R1 end flags", {ready, failed}, 0);
    check(!pddq, "R1 pddq", pddq, 0);
    check(!cmdValid && status == 2'd0, "R1 cmdValid/status", {cmdValid, status}, 0);
  endtask

  initial begin
    doReset();
    checkResetState();

    // Sweep: lock point across the retry window, several master latencies
    for (int la = 0; la <= POLLS + 1; la++) begin
      for (int l = 0; l < 3; l++) begin
        int expReads;
        bit expLock;
        lat = l; lockAfter = la; errAt = -1;
        clearLogs();
        pulseStart();
        waitEnd();
        expLock  = (la < POLLS);
        expReads = expLock ? la + 1 : POLLS;
        check(wrCnt == 1 && wrData == 16'h0001, "R2 reset write", int'(wrData) + (wrCnt << 16), 16'h0001 + (1 << 16));
        check(firstAddr == 16'h7F3F, "R2 first select", firstAddr, 16'h7F3F);
        check(firstStatCyc - writeCyc == DLY + 1, "R3 poll delay", firstStatCyc - writeCyc, DLY + 1);
        check(readIdx == expReads, expLock ? "R4 reads to lock" : "R5 reads to timeout", readIdx, expReads);
        if (expLock)
          check(ready && !failed && status == 2'd0, "R4 ready", {ready, failed, status}, 4'b1000);
        else
          check(!ready && failed && status == 2'd1, "R5 timeout", {ready, failed, status}, 4'b0101);
      end
    end
    checkQuiet("R9 quiet after end");

    // R6: error injected at every command position (lock on 3rd read)
    for (int e = 0; e < 7; e++) begin
      lat = 1; lockAfter = 2; errAt = e;
      clearLogs();
      pulseStart();
      waitEnd();
      check(failed && !ready && status == 2'd2, "R6 cmd error status", {ready, failed, status}, 4'b0110);
      check(ackIdx == e + 1, "R6 abort point", ackIdx, e + 1);
      check(wrCnt == (e == 0 ? 0 : 1), "R6 write count", wrCnt, e == 0 ? 0 : 1);
      checkQuiet("R6 no commands after abort");
    end
    errAt = -1;

    // R7: start pulses during a run are ignored
    lat = 0; lockAfter = 3;
    clearLogs();
    pulseStart();
    for (int k = 0; k < 30; k++) begin
      if (k % 4 == 1) startReq = 1;
      tick();
      startReq = 0;
    end
    waitEnd();
    check(wrCnt == 1, "R7 single reset write", wrCnt, 1);
    check(readIdx == 4 && ready, "R7 run completes", readIdx, 4);

    // R8: power-down at several points, then restart attempt, then reset
    for (int off = 0; off < 12; off += 3) begin
      lat = 1; lockAfter = 2;
      clearLogs();
      pulseStart();
      repeat (off) tick();
      pddqReq = 1; tick(); pddqReq = 0;
      check(pddq && failed && status == 2'd3, "R8 link off", {pddq, failed, status}, 4'b1111);
      pulseStart();
      validCnt = 0;
      repeat (20) tick();
      check(validCnt == 0 && failed && status == 2'd3, "R8 restart ignored", validCnt, 0);
      check(pddq, "R8 pddq sticky", pddq, 1);
      doReset();
      checkResetState();
    end

    // R8 from idle and R1 after final reset
    pddqReq = 1; tick(); pddqReq = 0;
    check(pddq && failed && status == 2'd3, "R8 idle power-down", {pddq, failed, status}, 4'b1111);
    doReset();
    checkResetState();

    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

endmodule